// File: doc/BRIEF.md
# Plotter DMA Completion and Interrupt Status

This block holds the completion and interrupt state for a DMA channel that feeds a raster plotter. Software drives it through two byte-wide write ports and one read port. Each bit of a command write triggers an action: it clears the channel, clears or enables attention, releases or holds the done flag, picks the source that sets done, or records the odd-transfer flag. The second write port is a one-bit interrupt-enable register. Reading the status port returns the latched flags and the current source selection.

Four events come in from the surrounding logic. The DMA engine sends an end-of-process pulse. The plotter presents a ready level. The memory path reports errors as a pulse, and the plotter raises attention as a pulse. The done flag rises on a rising edge of whichever source is selected. The end-of-process, memory-error and attention events each have their own sticky latch. Software treats a zero done bit as "transfer still busy". It polls the memory-error bit so that it can abort. The interrupt request combines done and enabled attention, and the interrupt-enable bit gates it.

A typical transfer runs as follows. Software writes 0x0C (hold done clear, select transfer-complete) and then 0x04 (release done). It starts the engine and waits for done.

Top module: `dma_done_irq`

## Requirements
- R1: After synchronous reset, status reads 0x00, `irq` is 0 and `chan_clear` is 0. Reset also clears attention-enable, interrupt-enable and both source selects.
- R2: Status bit 7 reads 0. Status bit 2 (complete source selected), bit 1 (ready source selected) and bit 0 (odd transfer) equal command bits 2, 1 and 0 of the most recent command write. They appear in the cycle after that write.
- R3: Command bit 3 is a held clear level taken from the most recent command write. The write that sets it clears done at its own clock edge. While the level is 1, done (status bit 3) stays 0 and no source event can set it.
- R4: When clear is released, done sets on a rising edge of a selected source. With command bit 2 selected, the source is an `eop_pulse` rising edge. With command bit 1 selected, the source is a `plotter_ready` rising edge. An unselected source, or a source that stays high, does not set done. Done stays set until it is cleared.
- R5: A command write with bit 7 set drives `chan_clear` high for exactly the cycle after the write. The same write clears the end-of-process latch (status bit 5) and the memory-error latch (status bit 4).
- R6: `eop_pulse` sets status bit 5 and `mem_err_pulse` sets status bit 4. Both bits hold until a channel clear. A pulse that arrives in the same cycle as the clearing write wins, so the bit stays set.
- R7: `attn_pulse` sets status bit 6, and a command write with bit 6 set clears it. Command bit 4 enables the attention interrupt and bit 5 disables it. If both bits are set, disable wins. A write with neither bit leaves the enable unchanged.
- R8: Bit 0 of an interrupt-enable write sets the enable. `irq` = enable AND (done OR (attention AND attention-enable)), and it follows the registered state with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | DATA_W | Command action bits |
| ien_we | input | 1 | Interrupt-enable write strobe |
| ien_wdata | input | DATA_W | Interrupt-enable data, bit 0 used |
| status_rdata | output | DATA_W | Latched status byte |
| eop_pulse | input | 1 | End-of-process from the DMA engine |
| plotter_ready | input | 1 | Plotter ready level |
| mem_err_pulse | input | 1 | Memory error event |
| attn_pulse | input | 1 | Plotter attention event |
| irq | output | 1 | Interrupt request |
| chan_clear | output | 1 | One-cycle plotter channel clear |

## Verification
The bench sweeps all 256 command codes with attention pending in each case. A decoder with swapped enable and disable priority, or one that latches the wrong bits, makes `irq` or the select and odd bits disagree on some codes. The directed scenarios go after the cases a careless design would get wrong:
- A done flag that sets on a level instead of an edge comes back right after clear-done is released while ready is still high.
- A done that ignores the selection rises on an end-of-process pulse while only ready is selected.
- A clear that applies late leaves done visible for one cycle after the 0x0C write.
- A clear-over-set latch drops a memory error that arrives together with a channel clear.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
   // command write bit positions (software-visible encoding)
   localparam int CMD_CHAN_CLR = 7;
   localparam int CMD_ATTN_CLR = 6;
   localparam int CMD_ATTN_DIS = 5;
   localparam int CMD_ATTN_EN  = 4;
   localparam int CMD_DONE_CLR = 3;
   localparam int CMD_SEL_CMPL = 2;
   localparam int CMD_SEL_RDY  = 1;
   localparam int CMD_ODD      = 0;

   // status read bit positions
   localparam int ST_ATTN     = 6;
   localparam int ST_EOP      = 5;
   localparam int ST_MERR     = 4;
   localparam int ST_DONE     = 3;
   localparam int ST_SEL_CMPL = 2;
   localparam int ST_SEL_RDY  = 1;
   localparam int ST_ODD      = 0;

   // sticky latch slots
   localparam int LT_DONE   = 0;
   localparam int LT_EOP    = 1;
   localparam int LT_MERR   = 2;
   localparam int LT_ATTN   = 3;
   localparam int NUM_LATCH = 4;

   localparam int CMD_BITS = 8;

   typedef struct packed {
      logic chan_clr;
      logic attn_clr;
      logic attn_dis;
      logic attn_en;
      logic done_clr;
      logic sel_cmpl;
      logic sel_rdy;
      logic odd;
   } cmd_bits_t;
endpackage

// File: rtl/dma_irq_edge.sv
module dma_irq_edge #(
   parameter int WIDTH       = 1,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] rise
);
   if (WIDTH < 1) begin : g_bad_width
      $error("dma_irq_edge: WIDTH must be at least 1");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("dma_irq_edge: SYNC_STAGES must lie in 0..4");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic s;
      logic prev;
      if (SYNC_STAGES == 0) begin : g_direct
         assign s = din[i];
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk) begin
            if (rst) begin
               sh <= '0;
            end else begin
               sh[0] <= din[i];
               for (int k = 1; k < SYNC_STAGES; k++) sh[k] <= sh[k-1];
            end
         end
         assign s = sh[SYNC_STAGES-1];
      end
      always_ff @(posedge clk) begin
         if (rst) prev <= 1'b0;
         else     prev <= s;
      end
      assign rise[i] = s & ~prev;
   end
endmodule

// File: rtl/dma_irq_sticky.sv
module dma_irq_sticky #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] set,
   input  logic [WIDTH-1:0] clr,
   output logic [WIDTH-1:0] q
);
   if (WIDTH < 1) begin : g_bad_width
      $error("dma_irq_sticky: WIDTH must be at least 1");
   end

   // a set in the same cycle as a clear wins, so no event is lost
   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= set | (q & ~clr);
   end
endmodule

// File: rtl/dma_irq_cmd.sv
module dma_irq_cmd
   import dma_irq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic              sel_cmpl,
   output logic              sel_rdy,
   output logic              odd,
   output logic              clr_level,
   output logic              clr_now,
   output logic              attn_en,
   output logic              attn_clr_now,
   output logic              chan_clr_now,
   output logic              chan_clear
);
   if (DATA_W < CMD_BITS) begin : g_bad_width
      $error("dma_irq_cmd: DATA_W must be at least 8");
   end

   cmd_bits_t c;
   assign c = cmd_bits_t'(wdata[CMD_BITS-1:0]);

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_cmpl   <= 1'b0;
         sel_rdy    <= 1'b0;
         odd        <= 1'b0;
         clr_level  <= 1'b0;
         attn_en    <= 1'b0;
         chan_clear <= 1'b0;
      end else begin
         chan_clear <= we & c.chan_clr;
         if (we) begin
            sel_cmpl  <= c.sel_cmpl;
            sel_rdy   <= c.sel_rdy;
            odd       <= c.odd;
            clr_level <= c.done_clr;
            if (c.attn_dis)     attn_en <= 1'b0;
            else if (c.attn_en) attn_en <= 1'b1;
         end
      end
   end

   // the writing edge already applies the new clear level
   assign clr_now      = we ? c.done_clr : clr_level;
   assign attn_clr_now = we & c.attn_clr;
   assign chan_clr_now = we & c.chan_clr;
endmodule

// File: rtl/dma_done_irq.sv
module dma_done_irq
   import dma_irq_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int READY_SYNC = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_we,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic              ien_we,
   input  logic [DATA_W-1:0] ien_wdata,
   output logic [DATA_W-1:0] status_rdata,
   input  logic              eop_pulse,
   input  logic              plotter_ready,
   input  logic              mem_err_pulse,
   input  logic              attn_pulse,
   output logic              irq,
   output logic              chan_clear
);
   if (DATA_W < CMD_BITS) begin : g_bad_width
      $error("dma_done_irq: DATA_W must be at least 8");
   end

   logic sel_cmpl, sel_rdy, odd, clr_level, clr_now;
   logic attn_en, attn_clr_now, chan_clr_now;
   logic eop_rise, rdy_rise, done_set;
   logic ien_q;
   logic [NUM_LATCH-1:0] lt_set, lt_clr, lt_q;
   logic done_q;

   dma_irq_cmd #(.DATA_W(DATA_W)) u_cmd (
      .clk(clk), .rst(rst), .we(cmd_we), .wdata(cmd_wdata),
      .sel_cmpl(sel_cmpl), .sel_rdy(sel_rdy), .odd(odd),
      .clr_level(clr_level), .clr_now(clr_now), .attn_en(attn_en),
      .attn_clr_now(attn_clr_now), .chan_clr_now(chan_clr_now),
      .chan_clear(chan_clear)
   );

   dma_irq_edge #(.WIDTH(1), .SYNC_STAGES(0)) u_eop_edge (
      .clk(clk), .rst(rst), .din(eop_pulse), .rise(eop_rise)
   );

   dma_irq_edge #(.WIDTH(1), .SYNC_STAGES(READY_SYNC)) u_rdy_edge (
      .clk(clk), .rst(rst), .din(plotter_ready), .rise(rdy_rise)
   );

   assign done_set = ((eop_rise & sel_cmpl) | (rdy_rise & sel_rdy)) & ~clr_now;

   always_comb begin
      lt_set          = '0;
      lt_clr          = '0;
      lt_set[LT_DONE] = done_set;
      lt_clr[LT_DONE] = clr_now;
      lt_set[LT_EOP]  = eop_pulse;
      lt_clr[LT_EOP]  = chan_clr_now;
      lt_set[LT_MERR] = mem_err_pulse;
      lt_clr[LT_MERR] = chan_clr_now;
      lt_set[LT_ATTN] = attn_pulse;
      lt_clr[LT_ATTN] = attn_clr_now;
   end

   dma_irq_sticky #(.WIDTH(NUM_LATCH)) u_latch (
      .clk(clk), .rst(rst), .set(lt_set), .clr(lt_clr), .q(lt_q)
   );

   assign done_q = lt_q[LT_DONE];

   always_ff @(posedge clk) begin
      if (rst)         ien_q <= 1'b0;
      else if (ien_we) ien_q <= ien_wdata[0];
   end

   always_comb begin
      status_rdata              = '0;
      status_rdata[ST_ATTN]     = lt_q[LT_ATTN];
      status_rdata[ST_EOP]      = lt_q[LT_EOP];
      status_rdata[ST_MERR]     = lt_q[LT_MERR];
      status_rdata[ST_DONE]     = done_q;
      status_rdata[ST_SEL_CMPL] = sel_cmpl;
      status_rdata[ST_SEL_RDY]  = sel_rdy;
      status_rdata[ST_ODD]      = odd;
   end

   assign irq = ien_q & (done_q | (lt_q[LT_ATTN] & attn_en));
endmodule

// File: rtl/dma_done_irq_chk.sv
module dma_done_irq_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              cmd_we,
   input logic [DATA_W-1:0] cmd_wdata,
   input logic              eop_pulse,
   input logic [DATA_W-1:0] status_rdata,
   input logic              irq,
   input logic              chan_clear,
   input logic              done_q,
   input logic              clr_level,
   input logic              sel_cmpl,
   input logic              sel_rdy,
   input logic              ien_q
);
   // R2: selects follow the last command write
   a_r2_sel_follows_write: assert property (@(posedge clk) disable iff (rst)
      cmd_we |=> (status_rdata[2:1] == $past(cmd_wdata[2:1])));

   // R3: a held clear keeps done low
   a_r3_clear_holds_done: assert property (@(posedge clk) disable iff (rst)
      clr_level |-> !done_q);

   // R4: done only rises with a source selected
   a_r4_done_needs_select: assert property (@(posedge clk) disable iff (rst)
      $rose(done_q) |-> ($past(sel_cmpl) || $past(sel_rdy)));

   // R4: without ready selected, a rise of done needs an end-of-process
   a_r4_done_from_eop: assert property (@(posedge clk) disable iff (rst)
      ($rose(done_q) && !$past(sel_rdy)) |-> $past(eop_pulse));

   // R5: channel clear pulse comes only from a bit-7 write
   a_r5_chan_clear_origin: assert property (@(posedge clk) disable iff (rst)
      chan_clear |-> $past(cmd_we && cmd_wdata[7]));

   // R6: end-of-process latch holds until a channel clear
   a_r6_eop_sticky: assert property (@(posedge clk) disable iff (rst)
      ($past(status_rdata[5]) && !$past(cmd_we && cmd_wdata[7])) |-> status_rdata[5]);

   // R8: interrupt masked without enable
   a_r8_irq_masked: assert property (@(posedge clk) disable iff (rst)
      !ien_q |-> !irq);

   // R8: done with enable raises the request
   a_r8_done_raises_irq: assert property (@(posedge clk) disable iff (rst)
      (ien_q && done_q) |-> irq);
endmodule

bind dma_done_irq dma_done_irq_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
   .eop_pulse(eop_pulse), .status_rdata(status_rdata), .irq(irq),
   .chan_clear(chan_clear), .done_q(done_q), .clr_level(clr_level),
   .sel_cmpl(sel_cmpl), .sel_rdy(sel_rdy), .ien_q(ien_q)
);

// File: tb/dma_done_irq_test.sv
`timescale 1ns/1ps
module dma_done_irq_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cmd_we = 1'b0;
   logic [7:0] cmd_wdata = '0;
   logic       ien_we = 1'b0;
   logic [7:0] ien_wdata = '0;
   logic [7:0] status_rdata;
   logic       eop_pulse = 1'b0;
   logic       plotter_ready = 1'b0;
   logic       mem_err_pulse = 1'b0;
   logic       attn_pulse = 1'b0;
   logic       irq;
   logic       chan_clear;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   dma_done_irq uut (
      .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
      .ien_we(ien_we), .ien_wdata(ien_wdata), .status_rdata(status_rdata),
      .eop_pulse(eop_pulse), .plotter_ready(plotter_ready),
      .mem_err_pulse(mem_err_pulse), .attn_pulse(attn_pulse),
      .irq(irq), .chan_clear(chan_clear)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      tick();
   endtask

   task automatic cmd(input logic [7:0] v);
      @(negedge clk);
      cmd_we = 1'b1;
      cmd_wdata = v;
      tick();
      cmd_we = 1'b0;
   endtask

   task automatic ien(input logic [7:0] v);
      @(negedge clk);
      ien_we = 1'b1;
      ien_wdata = v;
      tick();
      ien_we = 1'b0;
   endtask

   task automatic pulse_eop();
      @(negedge clk); eop_pulse = 1'b1; tick(); eop_pulse = 1'b0;
   endtask
   task automatic pulse_merr();
      @(negedge clk); mem_err_pulse = 1'b1; tick(); mem_err_pulse = 1'b0;
   endtask
   task automatic pulse_attn();
      @(negedge clk); attn_pulse = 1'b1; tick(); attn_pulse = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      tick();
      @(negedge clk);
      rst = 1'b0;
      #1;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(8 * 100000);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic en_model;
      do_reset();
      // R1: reset state
      chk("R1 status", status_rdata, 8'h00);
      chk("R1 irq", {7'd0, irq}, 8'h00);
      chk("R1 chan_clear", {7'd0, chan_clear}, 8'h00);

      // R2 R7: sweep every command code with attention pending
      ien(8'h01);
      en_model = 1'b0;
      for (int v = 0; v < 256; v++) begin
         logic [7:0] b;
         logic [7:0] exp_st;
         b = v[7:0];
         pulse_attn();
         cmd(b);
         if (b[5])      en_model = 1'b0;
         else if (b[4]) en_model = 1'b1;
         exp_st = {1'b0, ~b[6], 3'b000, b[2:0]};
         chk("R2 R7 sweep status", status_rdata, exp_st);
         chk("R7 R8 sweep irq", {7'd0, irq}, {7'd0, ~b[6] & en_model});
         chk("R5 sweep chan_clear", {7'd0, chan_clear}, {7'd0, b[7]});
      end

      // transfer-complete source
      do_reset();
      ien(8'h01);
      cmd(8'h0C);
      chk("R2 select complete", status_rdata, 8'h04);
      pulse_eop();
      chk("R3 held clear blocks done", status_rdata, 8'h24);
      cmd(8'h04);
      chk("R4 release no edge", status_rdata, 8'h24);
      pulse_eop();
      chk("R4 done on eop", status_rdata, 8'h2C);
      chk("R8 irq on done", {7'd0, irq}, 8'h01);
      ien(8'h00);
      chk("R8 irq masked", {7'd0, irq}, 8'h00);
      ien(8'h01);
      chk("R8 irq unmasked", {7'd0, irq}, 8'h01);

      // combined channel clear write
      cmd(8'h9C);
      chk("R5 clear write status", status_rdata, 8'h04);
      chk("R5 chan_clear high", {7'd0, chan_clear}, 8'h01);
      idle();
      chk("R5 chan_clear one cycle", {7'd0, chan_clear}, 8'h00);

      // plotter-ready source
      cmd(8'h02);
      chk("R3 release with ready", status_rdata, 8'h02);
      pulse_eop();
      chk("R4 unselected eop ignored", status_rdata, 8'h22);
      @(negedge clk); plotter_ready = 1'b1; tick();
      chk("R4 done on ready rise", status_rdata, 8'h2A);
      cmd(8'h0A);
      chk("R3 clear on write edge", status_rdata, 8'h22);
      cmd(8'h02);
      chk("R4 held ready no re-set", status_rdata, 8'h22);
      idle();
      chk("R4 held ready idle", status_rdata, 8'h22);
      @(negedge clk); plotter_ready = 1'b0; tick();
      @(negedge clk); plotter_ready = 1'b1; tick();
      chk("R4 second ready rise", status_rdata, 8'h2A);

      // memory error latch
      pulse_merr();
      chk("R6 memory error set", status_rdata, 8'h3A);
      @(negedge clk);
      cmd_we = 1'b1; cmd_wdata = 8'h82; mem_err_pulse = 1'b1;
      tick();
      cmd_we = 1'b0; mem_err_pulse = 1'b0;
      chk("R6 set beats clear", status_rdata, 8'h1A);
      cmd(8'h82);
      chk("R5 R6 clear memory error", status_rdata, 8'h0A);

      // attention enable priority
      cmd(8'h08);
      chk("R3 clear done", status_rdata, 8'h00);
      chk("R8 irq idle", {7'd0, irq}, 8'h00);
      cmd(8'h30);
      pulse_attn();
      chk("R7 attention latched", status_rdata, 8'h40);
      chk("R7 disable wins", {7'd0, irq}, 8'h00);
      cmd(8'h10);
      chk("R7 enable attention", {7'd0, irq}, 8'h01);
      cmd(8'h00);
      chk("R7 enable held", {7'd0, irq}, 8'h01);
      cmd(8'h40);
      chk("R7 clear attention", status_rdata, 8'h00);
      chk("R7 irq drops", {7'd0, irq}, 8'h00);

      finish_run();
   end
endmodule